// File: doc/BRIEF.md
# ECC Error Bit Corrector

This block applies already-located bit errors to a page that has been read from flash. The page is split into sectors. Each sector has a region of data bytes and a short run of stored check bytes. The two regions sit in two separate single-port byte RAMs outside the block, and the block drives their address, write-enable and write-data lines.

A run starts with a start pulse and a bitmap of the sectors that need repair. The block first scans the stored check bytes. If every one of them reads 0xFF, the page is taken to be erased and nothing is changed.

Otherwise the block visits the flagged sectors, lowest bit first. For each one it presents the sector number on `sect_idx` and reads back that sector's locator degree, root count and list of 1-based bit locations. It validates the whole sector, then flips each reported bit with a read cycle followed by a write cycle. A mismatch between the root count and the degree, or a location outside the search window, stops the run and raises `fail`. The running total of repaired bits is kept in `corr_cnt`.

Top module: `ecc_bit_fixer`

## Requirements
- R1: When every check byte of the page (addresses 0 to NSECT*EBYTES-1) reads 0xFF, the run ends with no RAM write, `fail` low and `corr_cnt` zero, whatever the bitmap holds.
- R2: Sectors are visited in rising index order. Bit i of `sect_map` selects sector i. A sector whose bit is clear is never written, even when its location list is non-empty.
- R3: A location L is turned into a byte index (L-1)/8 and a bit index (L-1) mod 8. When the byte index is below SECT_BYTES, bit (bit index) of data address sector*SECT_BYTES + byte index is inverted.
- R4: When the byte index is SECT_BYTES or more, the same bit of check-byte address sector*EBYTES + (byte index - SECT_BYTES) is inverted.
- R5: The parameters are derived as follows: m = 12 + SECT_BYTES/512, EBYTES = ceil(m*T/8), and valid locations are 1 to SECT_BYTES*8 + m*T. A location of 0 or above that bound in the first `loc_deg` entries sets `fail` and ends the run. No byte of that sector is touched.
- R6: When `loc_roots` differs from `loc_deg`, or `loc_deg` exceeds T, the sector is uncorrectable. `fail` is set, the run ends, no later sector is processed, and earlier sectors keep their corrections.
- R7: `corr_cnt` is cleared at start and grows by `loc_deg` for each sector that is fully corrected. A sector with degree 0 adds nothing.
- R8: Every flip is a read of an address followed, in the next cycle, by a write of the same address with one bit inverted. No RAM is written while `busy` is low.
- R9: `done` is a one-cycle pulse at the end of a run. `fail` and `corr_cnt` hold until the next accepted start. A start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when idle) |
| sect_map | input | NSECT | Sectors needing repair, bit i for sector i |
| sect_idx | output | SW | Sector whose locator data is being requested |
| loc_deg | input | DW | Locator degree of the requested sector |
| loc_roots | input | DW | Root count of the requested sector |
| loc_list | input | T*LW | 1-based bit locations, entry k at bits k*LW upward |
| d_addr | output | DAW | Data RAM address |
| d_we | output | 1 | Data RAM write enable |
| d_wdata | output | 8 | Data RAM write data |
| d_rdata | input | 8 | Data RAM read data, one cycle after address |
| e_addr | output | EAW | Check-byte RAM address |
| e_we | output | 1 | Check-byte RAM write enable |
| e_wdata | output | 8 | Check-byte RAM write data |
| e_rdata | input | 8 | Check-byte RAM read data, one cycle after address |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |
| fail | output | 1 | Last run hit an uncorrectable sector |
| corr_cnt | output | CW | Bits corrected in the last run |

## Verification
The bench builds the block with 512-byte sectors, T = 4 and four sectors. That gives m = 13, seven check bytes per sector and a 28-byte check region, so the all-0xFF scan finishes in a few dozen cycles. The search window ends at location 4148. Its last valid location lands in the seventh check byte of a sector, while 4149 falls inside that same byte and must still be rejected. The same run exercises the data/check boundary at locations 4096 and 4097, and the mapping of sector 3 onto the top of both RAMs.

// File: rtl/ecc_bit_fixer.sv
module ecc_bit_fixer #(
  parameter int SECT_BYTES = 512,
  parameter int T          = 4,
  parameter int NSECT      = 4,
  parameter int CW         = 16,
  parameter int M          = 12 + SECT_BYTES / 512,
  parameter int EBYTES     = (M * T + 7) / 8,
  parameter int SEARCH     = SECT_BYTES * 8 + M * T,
  parameter int LW         = $clog2(SEARCH + 1),
  parameter int DW         = $clog2(T + 1),
  parameter int SW         = (NSECT > 1) ? $clog2(NSECT) : 1,
  parameter int DAW        = $clog2(NSECT * SECT_BYTES),
  parameter int EAW        = $clog2(NSECT * EBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NSECT-1:0]  sect_map,
  output logic [SW-1:0]     sect_idx,
  input  logic [DW-1:0]     loc_deg,
  input  logic [DW-1:0]     loc_roots,
  input  logic [T*LW-1:0]   loc_list,
  output logic [DAW-1:0]    d_addr,
  output logic              d_we,
  output logic [7:0]        d_wdata,
  input  logic [7:0]        d_rdata,
  output logic [EAW-1:0]    e_addr,
  output logic              e_we,
  output logic [7:0]        e_wdata,
  input  logic [7:0]        e_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CW-1:0]     corr_cnt
);
  typedef enum logic [2:0] {
    S_IDLE, S_SCAN_RD, S_SCAN_CK, S_SEL, S_CHECK, S_RD, S_WR
  } st_t;

  st_t              st;
  logic [NSECT-1:0] map_q;
  logic [EAW-1:0]   scan_i;
  logic [SW-1:0]    sect;
  logic [DW-1:0]    j;
  logic [T-1:0]     bad;

  logic [LW-1:0]    cur, lm1;
  logic [LW-4:0]    byte_i;
  logic [2:0]       bit_i;
  logic             in_data, scanning, last_sect, sect_bad;

  assign cur      = loc_list[j*LW +: LW];
  assign lm1      = cur - LW'(1);
  assign byte_i   = lm1[LW-1:3];
  assign bit_i    = lm1[2:0];
  assign in_data  = 32'(byte_i) < SECT_BYTES;
  assign scanning = (st == S_SCAN_RD) || (st == S_SCAN_CK);
  assign last_sect = 32'(sect) == NSECT - 1;

  for (genvar k = 0; k < T; k++) begin : g_chk
    assign bad[k] = (k < 32'(loc_deg)) &&
                    ((loc_list[k*LW +: LW] == '0) || (32'(loc_list[k*LW +: LW]) > SEARCH));
  end

  assign sect_bad = (|bad) || (loc_roots != loc_deg) || (32'(loc_deg) > T);

  assign sect_idx = sect;
  assign busy     = st != S_IDLE;
  assign d_addr   = DAW'(32'(sect) * SECT_BYTES + 32'(byte_i));
  assign e_addr   = scanning ? scan_i
                             : EAW'(32'(sect) * EBYTES + 32'(byte_i) - SECT_BYTES);
  assign d_we     = (st == S_WR) && in_data;
  assign e_we     = (st == S_WR) && !in_data;
  assign d_wdata  = d_rdata ^ (8'd1 << bit_i);
  assign e_wdata  = e_rdata ^ (8'd1 << bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      map_q    <= '0;
      scan_i   <= '0;
      sect     <= '0;
      j        <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      corr_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          map_q    <= sect_map;
          scan_i   <= '0;
          sect     <= '0;
          fail     <= 1'b0;
          corr_cnt <= '0;
          st       <= S_SCAN_RD;
        end
        S_SCAN_RD: st <= S_SCAN_CK;
        S_SCAN_CK:
          if (e_rdata != 8'hFF) st <= S_SEL;
          else if (32'(scan_i) == NSECT * EBYTES - 1) begin
            st <= S_IDLE; done <= 1'b1;
          end else begin
            scan_i <= scan_i + 1'b1; st <= S_SCAN_RD;
          end
        S_SEL:
          if (map_q[sect]) st <= S_CHECK;
          else if (last_sect) begin st <= S_IDLE; done <= 1'b1; end
          else sect <= sect + 1'b1;
        S_CHECK:
          if (sect_bad) begin
            fail <= 1'b1; st <= S_IDLE; done <= 1'b1;
          end else if (loc_deg == '0) begin
            if (last_sect) begin st <= S_IDLE; done <= 1'b1; end
            else begin sect <= sect + 1'b1; st <= S_SEL; end
          end else begin
            j <= '0; st <= S_RD;
          end
        S_RD: st <= S_WR;
        S_WR:
          if (32'(j) + 1 == 32'(loc_deg)) begin
            corr_cnt <= corr_cnt + CW'(loc_deg);
            if (last_sect) begin st <= S_IDLE; done <= 1'b1; end
            else begin sect <= sect + 1'b1; st <= S_SEL; end
          end else begin
            j <= j + 1'b1; st <= S_RD;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_bit_fixer_chk.sv
module ecc_bit_fixer_chk #(
  parameter int CW  = 16,
  parameter int DAW = 11,
  parameter int EAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input logic [CW-1:0]  corr_cnt,
  input logic           d_we,
  input logic [DAW-1:0] d_addr,
  input logic           e_we,
  input logic [EAW-1:0] e_addr
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!d_we && !e_we)); // R8
  AST_DATA_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> (!$past(d_we) && d_addr == $past(d_addr))); // R8
  AST_ECC_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> (!$past(e_we) && e_addr == $past(e_addr))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fail) && $stable(corr_cnt))); // R9
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!d_we && !e_we)); // R6
  AST_CNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (corr_cnt >= $past(corr_cnt))); // R7
endmodule

bind ecc_bit_fixer ecc_bit_fixer_chk #(.CW(CW), .DAW(DAW), .EAW(EAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .corr_cnt(corr_cnt), .d_we(d_we), .d_addr(d_addr),
  .e_we(e_we), .e_addr(e_addr)
);

// File: tb/test_ecc_bit_fixer.sv
module test_ecc_bit_fixer;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 512;
  localparam int TT = 4;
  localparam int NS = 4;
  localparam int EB = 7;
  localparam int LW = 13;
  localparam int ND = NS * SB;
  localparam int NE = NS * EB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NS-1:0] sect_map = '0;
  logic [1:0] sect_idx;
  logic [2:0] loc_deg, loc_roots;
  logic [TT*LW-1:0] loc_list;
  logic [10:0] d_addr;
  logic [4:0] e_addr;
  logic d_we, e_we, busy, done, fail;
  logic [7:0] d_wdata, e_wdata, d_rdata, e_rdata;
  logic [15:0] corr_cnt;

  int total = 0, bad = 0;
  logic [7:0] dmem [ND];
  logic [7:0] emem [NE];
  logic [7:0] xd [ND];
  logic [7:0] xe [NE];
  logic [2:0] deg_a [NS];
  logic [2:0] roots_a [NS];
  logic [LW-1:0] loc_a [NS][TT];
  logic ld = 1'b0;
  int seed = 0, hole = -1;
  bit eff = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_bit_fixer #(.SECT_BYTES(SB), .T(TT), .NSECT(NS)) i_ecc_bit_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_map(sect_map),
    .sect_idx(sect_idx), .loc_deg(loc_deg), .loc_roots(loc_roots),
    .loc_list(loc_list), .d_addr(d_addr), .d_we(d_we), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .e_addr(e_addr), .e_we(e_we), .e_wdata(e_wdata),
    .e_rdata(e_rdata), .busy(busy), .done(done), .fail(fail),
    .corr_cnt(corr_cnt));

  function automatic logic [7:0] dpat(int i);
    return 8'(i * 7 + seed * 13 + (i >> 3));
  endfunction
  function automatic logic [7:0] epat(int i);
    if (i == hole) return 8'h12;
    return eff ? 8'hFF : 8'(i * 29 + seed * 5 + 3);
  endfunction

  always @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < ND; i++) dmem[i] <= dpat(i);
      for (int i = 0; i < NE; i++) emem[i] <= epat(i);
    end else begin
      if (d_we) dmem[d_addr] <= d_wdata;
      if (e_we) emem[e_addr] <= e_wdata;
    end
    d_rdata <= dmem[d_addr];
    e_rdata <= emem[e_addr];
  end

  always_comb begin
    loc_deg = deg_a[sect_idx];
    loc_roots = roots_a[sect_idx];
    for (int k = 0; k < TT; k++) loc_list[k*LW +: LW] = loc_a[sect_idx][k];
  end

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic load(int s, bit all_ff, int h);
    seed = s; eff = all_ff; hole = h;
    for (int i = 0; i < ND; i++) xd[i] = 8'h00;
    for (int i = 0; i < NE; i++) xe[i] = 8'h00;
    for (int s2 = 0; s2 < NS; s2++) begin
      deg_a[s2] = 3'd0; roots_a[s2] = 3'd0;
      for (int k = 0; k < TT; k++) loc_a[s2][k] = '0;
    end
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic set_sect(int s, int d, int r, int l0, int l1, int l2, int l3);
    deg_a[s] = 3'(d); roots_a[s] = 3'(r);
    loc_a[s][0] = LW'(l0); loc_a[s][1] = LW'(l1);
    loc_a[s][2] = LW'(l2); loc_a[s][3] = LW'(l3);
  endtask

  task automatic exp_flip(int s, int loc);
    int l, b;
    l = loc - 1; b = l / 8;
    if (b < SB) xd[s*SB + b] ^= 8'(1 << (l % 8));
    else        xe[s*EB + b - SB] ^= 8'(1 << (l % 8));
  endtask

  task automatic run(logic [NS-1:0] m, bit poke);
    int n;
    @(negedge clk); sect_map = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      sect_map = '1; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R9 done seen", 32'(done), 32'd1);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic cmp_mem(string r);
    int nd = 0, fi = -1;
    logic [7:0] g = 8'h00, e = 8'h00;
    for (int i = 0; i < ND; i++)
      if (dmem[i] !== (dpat(i) ^ xd[i])) begin
        nd++; if (fi < 0) begin fi = i; g = dmem[i]; e = dpat(i) ^ xd[i]; end
      end
    for (int i = 0; i < NE; i++)
      if (emem[i] !== (epat(i) ^ xe[i])) begin
        nd++; if (fi < 0) begin fi = ND + i; g = emem[i]; e = epat(i) ^ xe[i]; end
      end
    total++;
    if (nd != 0) begin
      bad++;
      $display("FAIL %s: %0d bytes differ, first at %0d got %0h expected %0h", r, nd, fi, g, e);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset busy", 32'(busy), 0);
    chk("R9 reset done", 32'(done), 0);
    chk("R6 reset fail", 32'(fail), 0);
    chk("R7 reset count", 32'(corr_cnt), 0);
    chk("R8 reset no write", 32'(d_we | e_we), 0);
  endtask

  task automatic t_erased();
    load(1, 1'b1, -1);
    set_sect(0, 2, 2, 5, 4097, 0, 0);
    set_sect(2, 1, 1, 100, 0, 0, 0);
    run(4'b1111, 1'b0);
    chk("R1 erased fail", 32'(fail), 0);
    chk("R1 erased count", 32'(corr_cnt), 0);
    cmp_mem("R1 erased untouched");
  endtask

  task automatic t_data();
    load(2, 1'b0, -1);
    set_sect(0, 2, 2, 1, 4096, 0, 0);
    set_sect(1, 3, 3, 10, 20, 30, 0);
    set_sect(2, 1, 1, 9, 0, 0, 0);
    set_sect(3, 0, 0, 0, 0, 0, 0);
    exp_flip(0, 1); exp_flip(0, 4096); exp_flip(2, 9);
    run(4'b1101, 1'b0);
    chk("R7 data count", 32'(corr_cnt), 3);
    chk("R3 data fail", 32'(fail), 0);
    cmp_mem("R3 R2 data flips and skipped sector");
  endtask

  task automatic t_ecc();
    load(3, 1'b1, 5);
    set_sect(3, 4, 4, 4097, 4148, 4000, 2053);
    exp_flip(3, 4097); exp_flip(3, 4148); exp_flip(3, 4000); exp_flip(3, 2053);
    run(4'b1000, 1'b0);
    chk("R4 ecc count", 32'(corr_cnt), 4);
    chk("R5 upper bound accepted", 32'(fail), 0);
    cmp_mem("R4 ecc region mapping");
  endtask

  task automatic t_roots();
    load(4, 1'b0, -1);
    set_sect(0, 1, 1, 17, 0, 0, 0);
    set_sect(1, 2, 1, 40, 50, 0, 0);
    set_sect(2, 1, 1, 60, 0, 0, 0);
    exp_flip(0, 17);
    run(4'b0111, 1'b0);
    chk("R6 mismatch fail", 32'(fail), 1);
    chk("R6 earlier sector counted", 32'(corr_cnt), 1);
    cmp_mem("R6 stop at bad sector");
    load(5, 1'b0, -1);
    set_sect(0, 5, 5, 3, 4, 5, 6);
    run(4'b0001, 1'b0);
    chk("R6 degree above T fail", 32'(fail), 1);
    cmp_mem("R6 degree above T untouched");
  endtask

  task automatic t_range();
    load(6, 1'b0, -1);
    set_sect(0, 2, 2, 33, 4149, 0, 0);
    run(4'b0001, 1'b0);
    chk("R5 above window fail", 32'(fail), 1);
    chk("R5 above window count", 32'(corr_cnt), 0);
    cmp_mem("R5 above window untouched");
    load(7, 1'b0, -1);
    set_sect(1, 2, 2, 0, 70, 0, 0);
    run(4'b0010, 1'b0);
    chk("R5 zero location fail", 32'(fail), 1);
    cmp_mem("R5 zero location untouched");
  endtask

  task automatic t_busy_start();
    load(8, 1'b1, 27);
    set_sect(0, 1, 1, 2, 0, 0, 0);
    set_sect(1, 1, 1, 44, 0, 0, 0);
    set_sect(2, 2, 2, 3, 4100, 0, 0);
    set_sect(3, 1, 1, 77, 0, 0, 0);
    exp_flip(0, 2); exp_flip(2, 3); exp_flip(2, 4100);
    run(4'b0101, 1'b1);
    chk("R9 start while busy ignored count", 32'(corr_cnt), 3);
    cmp_mem("R9 start while busy ignored data");
    repeat (5) @(negedge clk);
    chk("R9 count holds when idle", 32'(corr_cnt), 3);
    chk("R9 fail holds when idle", 32'(fail), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        total++; bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin deg_a[i] = '0; roots_a[i] = '0; end
    for (int i = 0; i < NS; i++) for (int k = 0; k < TT; k++) loc_a[i][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_data();
    t_ecc();
    t_roots();
    t_range();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule